// File: doc/BRIEF.md
# Flash Operation Timer and Completion Polling Unit

This block sits beside the command decoder of an on-chip flash programming path. Each time the decoder issues a start request with an operation kind, the block measures out that operation's duration in clock cycles. It drives an active-low ready/busy pin for the host to watch, and it gives the decoder a one-cycle completion pulse when the time is up. The block does not touch any flash cells. It only keeps time.

While an operation is in flight, the block also owns the verify-read data path. A host that reads during that time gets a polling byte built from the byte last loaded, whatever address it presents. Once the block is idle again, array read data passes through unchanged. Each duration is set in microseconds together with the programming clock rate. The block converts them to cycle counts at elaboration, so the counts follow the clock frequency.

Top module: `fbs_status_unit`

## Requirements
- R1: After reset, `rdy_o` is 1, `done_o` is 0 and `rd_data_o` equals `arr_rd_i`.
- R2: A start is accepted at the clock edge where `start_i` is 1, the block is idle and `op_i` is valid. `rdy_o` falls exactly `LAUNCH_CYC` edges after the accepting edge.
- R3: `rdy_o` stays low for exactly the duration of the accepted operation, then rises. That duration is ceil(us × `CLK_KHZ` / 1000) cycles, with a minimum of 1. Each kind has its own microsecond parameter. The `op_i` encoding is: 0 byte program, 1 security/remap bit, 2 sector erase, 3 partition erase, 4 chip erase.
- R4: `done_o` is high for exactly one cycle per accepted operation, at the same edge where `rdy_o` returns high.
- R5: A start request that arrives while an operation is pending or running is ignored. It does not change the timing or the latched byte.
- R6: A start request with `op_i` equal to 5, 6 or 7 is ignored. `rdy_o` stays high, no `done_o` follows, and reads keep passing through.
- R7: From the accepting edge until `done_o`, `rd_data_o` is {4'b0, ~L[3], 3'b0}, where L is the latched byte. This holds regardless of `arr_rd_i`.
- R8: An accepted program kind (codes 0, 1) latches `data_i`. An accepted erase kind (codes 2 to 4) latches 8'hFF, so its polling byte is 8'h00.
- R9: While idle, `rd_data_o` equals `arr_rd_i` combinationally.
- R10: A start presented in the same cycle that `done_o` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Programming clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request from the command decoder |
| op_i | input | 3 | Operation kind for the start request |
| data_i | input | 8 | Byte loaded with a program request |
| arr_rd_i | input | 8 | Read data from the flash array |
| rd_data_o | output | 8 | Verify-read data toward the host |
| rdy_o | output | 1 | Ready/busy pin, low while an operation runs |
| done_o | output | 1 | One-cycle completion pulse to the decoder |

## Verification
The assertions take two things for granted. First, `start_i` and `op_i` are stable around the clock edge. Second, `arr_rd_i` matters only while the block is idle. Beyond that, start requests may arrive at any time, including while busy and with illegal codes.

The stimulus drives every input on the falling edge and samples on the falling edge. It deliberately fires extra starts during both the launch delay and the run phase. It also issues codes 5 to 7, and it chains operations so that a new start lands in the completion cycle. Random data bytes and random array read data come from a fixed seed. Both polling values (bit 3 set and bit 3 clear) are therefore exercised.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  typedef enum logic [2:0] {
    OP_BYTE   = 3'd0,
    OP_SECBIT = 3'd1,
    OP_SECTOR = 3'd2,
    OP_PART   = 3'd3,
    OP_CHIP   = 3'd4
  } fbs_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_RUN  = 2'd2
  } fbs_state_e;

  localparam int unsigned NUM_OPS = 5;

  // microseconds at a given kHz clock, rounded up, never below one cycle
  function automatic int unsigned us_to_cyc(input int unsigned us,
                                            input int unsigned khz);
    longint unsigned prod;
    longint unsigned cyc;
    prod = longint'(us) * longint'(khz);
    cyc  = (prod + 64'd999) / 64'd1000;
    if (cyc == 64'd0) cyc = 64'd1;
    return int'(cyc[31:0]);
  endfunction

  function automatic logic op_valid(input logic [2:0] op);
    return op < 3'(NUM_OPS);
  endfunction

  function automatic logic op_is_erase(input logic [2:0] op);
    return (op == OP_SECTOR) || (op == OP_PART) || (op == OP_CHIP);
  endfunction

  function automatic logic [7:0] poll_byte(input logic [7:0] last);
    return {4'b0000, ~last[3], 3'b000};
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fbs_dur_sel.sv
module fbs_dur_sel
  import fbs_pkg::*;
#(
  parameter int unsigned CW     = 8,
  parameter int unsigned D_BYTE = 10,
  parameter int unsigned D_SEC  = 10,
  parameter int unsigned D_SECT = 100,
  parameter int unsigned D_PART = 1000,
  parameter int unsigned D_CHIP = 1200
) (
  input  logic [2:0]    op_i,
  output logic          valid_o,
  output logic [CW-1:0] last_o
);

  logic [CW-1:0] tab [NUM_OPS];

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_tab
    localparam int unsigned DV = (g == 0) ? D_BYTE :
                                 (g == 1) ? D_SEC  :
                                 (g == 2) ? D_SECT :
                                 (g == 3) ? D_PART : D_CHIP;
    assign tab[g] = CW'(DV - 1);
  end

  always_comb begin
    valid_o = op_valid(op_i);
    last_o  = '0;
    for (int k = 0; k < NUM_OPS; k++) begin
      if (op_i == 3'(k)) last_o = tab[k];
    end
  end

endmodule

// File: rtl/fbs_timer.sv
module fbs_timer
  import fbs_pkg::*;
#(
  parameter int unsigned CW         = 8,
  parameter int unsigned LAUNCH_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          valid_i,
  input  logic [CW-1:0] dur_last_i,
  output logic          busy_o,
  output logic          accept_o,
  output logic          expire_o,
  output logic          rdy_o,
  output logic          done_o
);

  localparam logic [CW-1:0] LAUNCH_LAST = CW'(LAUNCH_CYC - 1);

  fbs_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] run_last_q;
  logic          cnt_zero;
  logic          launch_end;

  assign cnt_zero   = (cnt_q == '0);
  assign busy_o     = (state_q != ST_IDLE);
  assign accept_o   = start_i && valid_i && !busy_o;
  assign launch_end = (state_q == ST_PEND) && cnt_zero;
  assign expire_o   = (state_q == ST_RUN) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      run_last_q <= '0;
      rdy_o      <= 1'b1;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            state_q    <= ST_PEND;
            cnt_q      <= LAUNCH_LAST;
            run_last_q <= dur_last_i;
          end
        end
        ST_PEND: begin
          if (launch_end) begin
            state_q <= ST_RUN;
            cnt_q   <= run_last_q;
            rdy_o   <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RUN: begin
          if (expire_o) begin
            state_q <= ST_IDLE;
            rdy_o   <= 1'b1;
            done_o  <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fbs_poll.sv
module fbs_poll
  import fbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept_i,
  input  logic [2:0] op_i,
  input  logic [7:0] data_i,
  input  logic       busy_i,
  input  logic [7:0] arr_rd_i,
  output logic [7:0] rd_data_o,
  output logic [7:0] last_o
);

  logic [7:0] last_q;
  logic [7:0] load_val;

  assign load_val = op_is_erase(op_i) ? 8'hFF : data_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 8'hFF;
    else if (accept_i) last_q <= load_val;
  end

  assign last_o    = last_q;
  assign rd_data_o = busy_i ? poll_byte(last_q) : arr_rd_i;

endmodule

// File: rtl/fbs_status_unit.sv
module fbs_status_unit
  import fbs_pkg::*;
#(
  parameter int unsigned CLK_KHZ     = 10000,
  parameter int unsigned LAUNCH_CYC  = 2,
  parameter int unsigned T_BYTE_US   = 100,
  parameter int unsigned T_SECBIT_US = 100,
  parameter int unsigned T_SECTOR_US = 30000,
  parameter int unsigned T_PART_US   = 300000,
  parameter int unsigned T_CHIP_US   = 350000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [2:0] op_i,
  input  logic [7:0] data_i,
  input  logic [7:0] arr_rd_i,
  output logic [7:0] rd_data_o,
  output logic       rdy_o,
  output logic       done_o
);

  localparam int unsigned D_BYTE = us_to_cyc(T_BYTE_US, CLK_KHZ);
  localparam int unsigned D_SEC  = us_to_cyc(T_SECBIT_US, CLK_KHZ);
  localparam int unsigned D_SECT = us_to_cyc(T_SECTOR_US, CLK_KHZ);
  localparam int unsigned D_PART = us_to_cyc(T_PART_US, CLK_KHZ);
  localparam int unsigned D_CHIP = us_to_cyc(T_CHIP_US, CLK_KHZ);
  localparam int unsigned D_MAX  = max2(max2(max2(D_BYTE, D_SEC), max2(D_SECT, D_PART)),
                                        max2(D_CHIP, LAUNCH_CYC));
  localparam int unsigned CW     = $clog2(D_MAX + 1);

  logic          valid_w;
  logic [CW-1:0] dur_last_w;
  logic          busy_w;
  logic          accept_w;
  logic          expire_w;
  logic [7:0]    last_w;

  fbs_dur_sel #(
    .CW(CW), .D_BYTE(D_BYTE), .D_SEC(D_SEC), .D_SECT(D_SECT),
    .D_PART(D_PART), .D_CHIP(D_CHIP)
  ) u_dur (
    .op_i    (op_i),
    .valid_o (valid_w),
    .last_o  (dur_last_w)
  );

  fbs_timer #(.CW(CW), .LAUNCH_CYC(LAUNCH_CYC)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .valid_i    (valid_w),
    .dur_last_i (dur_last_w),
    .busy_o     (busy_w),
    .accept_o   (accept_w),
    .expire_o   (expire_w),
    .rdy_o      (rdy_o),
    .done_o     (done_o)
  );

  fbs_poll u_poll (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept_w),
    .op_i      (op_i),
    .data_i    (data_i),
    .busy_i    (busy_w),
    .arr_rd_i  (arr_rd_i),
    .rd_data_o (rd_data_o),
    .last_o    (last_w)
  );

endmodule

// File: rtl/fbs_status_chk.sv
module fbs_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [2:0] op_i,
  input logic [7:0] arr_rd_i,
  input logic [7:0] rd_data_o,
  input logic       rdy_o,
  input logic       done_o,
  input logic       busy_w,
  input logic       accept_w,
  input logic       expire_w,
  input logic [7:0] last_w
);

  // R2
  fall_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_o) |-> $past(busy_w));

  // R3
  low_means_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_o |-> busy_w);

  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R4
  done_with_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> (done_o && $rose(rdy_o)));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && start_i) |=> $stable(last_w));

  // R6
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_w && start_i && op_i > 3'd4) |=> !busy_w);

  // R7
  poll_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> (rd_data_o[7:4] == 4'h0 && rd_data_o[2:0] == 3'h0
                && rd_data_o[3] == !last_w[3]));

  // R9
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> rd_data_o == arr_rd_i);

  // R10
  b2b_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i && op_i <= 3'd4) |-> accept_w);

endmodule

bind fbs_status_unit fbs_status_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .op_i      (op_i),
  .arr_rd_i  (arr_rd_i),
  .rd_data_o (rd_data_o),
  .rdy_o     (rdy_o),
  .done_o    (done_o),
  .busy_w    (busy_w),
  .accept_w  (accept_w),
  .expire_w  (expire_w),
  .last_w    (last_w)
);

// File: tb/test_fbs_status_unit.sv
module test_fbs_status_unit;

  localparam int CLK_PERIOD = 10;
  localparam int KHZ        = 100;
  localparam int LCH        = 3;
  localparam int WD_CYCLES  = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] op_i = 3'd0;
  logic [7:0] data_i = 8'h00;
  logic [7:0] arr_rd_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       rdy_o;
  logic       done_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fbs_status_unit #(.CLK_KHZ(KHZ), .LAUNCH_CYC(LCH)) i_fbs_status_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .data_i(data_i),
    .arr_rd_i(arr_rd_i), .rd_data_o(rd_data_o), .rdy_o(rdy_o), .done_o(done_o)
  );

  function automatic int exp_cycles(input int op);
    longint us, q;
    case (op)
      0: us = 100;
      1: us = 100;
      2: us = 30000;
      3: us = 300000;
      default: us = 350000;
    endcase
    q = (us * KHZ) / 1000;
    if (q * 1000 < us * KHZ) q = q + 1;
    if (q < 1) q = 1;
    return int'(q);
  endfunction

  function automatic logic [7:0] exp_poll(input logic [7:0] b);
    logic [7:0] r = 8'h00;
    r[3] = (b[3] == 1'b0);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input int op, input logic [7:0] dat, input bit inject,
                        input bit b2b);
    int d, fall, rise, dn, ndone, pbad, pact, pexp;
    logic [7:0] last;
    bit was_done;
    d = exp_cycles(op);
    last = (op >= 2) ? 8'hFF : dat;
    was_done = done_o;
    start_i = 1'b1; op_i = 3'(op); data_i = dat;
    fall = -1; rise = -1; dn = -1; ndone = 0; pbad = 0; pact = 0; pexp = 0;
    for (int n = 0; n <= LCH + d; n++) begin
      @(negedge clk);
      if (!rdy_o && fall < 0) fall = n;
      if (rdy_o && fall >= 0 && rise < 0) rise = n;
      if (done_o) begin ndone++; dn = n; end
      if (n < LCH + d) begin
        if (rd_data_o !== exp_poll(last)) begin
          pbad++; pact = rd_data_o; pexp = exp_poll(last);
        end
      end else begin
        // R9 idle passthrough right after completion
        chk(rd_data_o === arr_rd_i, "R9", "idle read", rd_data_o, arr_rd_i);
      end
      if (inject && (n == 1 || n == LCH + 1)) begin
        start_i = 1'b1; op_i = 3'd0; data_i = ~dat;
      end else begin
        start_i = 1'b0;
      end
      arr_rd_i = 8'($urandom);
    end
    if (b2b) chk(was_done && fall == LCH, "R10", "start in done cycle", fall, LCH);
    chk(fall == LCH, "R2", "busy fall cycle", fall, LCH);
    chk(rise == LCH + d, inject ? "R5" : "R3", "ready rise cycle", rise, LCH + d);
    chk(ndone == 1 && dn == LCH + d, "R4", "done pulse", dn, LCH + d);
    chk(pbad == 0, (op >= 2) ? "R8" : "R7", "poll byte", pact, pexp);
  endtask

  task automatic bad_code(input int op);
    int errs = 0;
    start_i = 1'b1; op_i = 3'(op); data_i = 8'h00;
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (!rdy_o || done_o || rd_data_o !== arr_rd_i) errs++;
      arr_rd_i = 8'($urandom);
    end
    // R6 code 5..7 never starts anything
    chk(errs == 0, "R6", "illegal code ignored", errs, 0);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    arr_rd_i = 8'h5A;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk(rdy_o === 1'b1, "R1", "reset ready", rdy_o, 1);
    chk(done_o === 1'b0, "R1", "reset done", done_o, 0);
    chk(rd_data_o === 8'h5A, "R1", "reset read", rd_data_o, 8'h5A);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    // directed: both polling values, erase latch, ignore windows
    run_op(0, 8'h08, 1'b0, 1'b0);
    run_op(0, 8'h00, 1'b1, 1'b1);
    run_op(1, 8'hF7, 1'b0, 1'b1);
    run_op(2, 8'h00, 1'b1, 1'b1);
    @(negedge clk);
    bad_code(5);
    bad_code(6);
    bad_code(7);
    // random mix of short kinds
    for (int k = 0; k < 8; k++) begin
      int op = int'($urandom % 3);
      run_op(op, 8'($urandom), bit'($urandom % 2), k > 0);
    end
    run_op(3, 8'h3C, 1'b1, 1'b1);
    run_op(4, 8'h00, 1'b0, 1'b1);
    ended = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule